// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Controller

This block is an SPI flash master. Software reaches it through two doors: a small register port that holds a configuration word and a 32-bit control word, and a byte-wide memory window on the system bus. The control word decides how a window access becomes SPI traffic.

In the automatic read modes, each window read becomes one complete transaction. The controller lowers chip select and sends an opcode and the address, most significant byte first. It then sends any dummy bytes and collects one data byte, either on one line or on two. After that it raises chip select and holds it high for a programmed idle time before the next transaction may start.

In user mode, chip select follows one bit of the control word. Each window write shifts one raw byte out, and each window read clocks one raw byte in. Software uses this to frame arbitrary flash commands such as erase, program and status reads. A lock bit in the configuration word must be set before the control word accepts a write.

Top module: `spiFlashCtl`

## Requirements
- R1: A write to the control word (regSel=1) takes effect only while bit 0 of the configuration word (regSel=0) is set; otherwise it is ignored. regRdata returns the word selected by regSel: the full 32-bit control word, or the configuration word with only bit 0 implemented.
- R2: In normal read mode (control bits [1:0] = 0, and also the unused value 2), a window read sends opcode 0x03 and the address bytes, with no dummy bytes. It then clocks one data byte in on spiIo1In. The opcode field and the dummy field are ignored in this mode.
- R3: In fast read mode (bits [1:0] = 1), the opcode is taken from bits [23:16]. The address is followed by as many 0x00 dummy bytes as bits [7:6] give.
- R4: Address bytes go out most significant byte first. With bit 13 clear, the low three bytes of winAddr are sent; with bit 13 set, all four bytes are sent.
- R5: In fast read with bits [29:28] = 2, the data byte arrives on two lines, two bits per clock, with spiIo1In carrying the higher bit of each pair. spiIo0Oe is low during that byte, while opcode, address and dummy stay single-line.
- R6: In user mode (bits [1:0] = 3), spiCsN equals control bit 2. A window write shifts winWdata out on spiIo0Out. A window read shifts out 0x00 and returns the eight bits sampled on spiIo1In, first bit as the MSB.
- R7: Outside user mode, a window write is acknowledged with no SPI clock edges, and spiCsN stays high.
- R8: Before spiCsN goes low for an automatic read, it has been high for at least 16 minus bits [27:24] bus clock cycles.
- R9: spiClk idles low. While a byte is being shifted, each high phase and each low phase of spiClk lasts 8 minus bits [10:8] bus clock cycles, so 7 gives divide-by-2 and 4 gives divide-by-8. Data is sampled on the rising edge.
- R10: After reset, spiCsN and winReady read 1 and 0, spiClk is low, and both the control word and the configuration word read zero.
- R11: Each window access is answered by a single-cycle winReady pulse, and winRdata holds the returned byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the configuration word, 1 the control word |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Selected register contents |
| winReq | input | 1 | Window access request, held until winReady |
| winWr | input | 1 | 1 for a window write, 0 for a read |
| winAddr | input | ADDR_W | Window byte address |
| winWdata | input | 8 | Window write byte |
| winReady | output | 1 | Access complete pulse |
| winRdata | output | 8 | Byte returned by a window read |
| spiClk | output | 1 | SPI serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiIo0Out | output | 1 | Serial data out on line 0 |
| spiIo0Oe | output | 1 | Output enable of line 0 |
| spiIo0In | input | 1 | Line 0 input, used by dual reads |
| spiIo1In | input | 1 | Line 1 input, serial data from the flash |

## Verification
The bench attaches a behavioural flash to the pins and checks the exact byte stream on line 0 for each mode. A design that ignored the opcode field in fast read would send 0x03 where 0x0B or 0x3B is expected. A design that sent 0x3B in normal read, or added dummy bytes there, would produce an extra or wrong byte. A design that sent the address least significant byte first, or always sent three address bytes, would fail the four-byte case. Dual reads are checked for the returned byte and for the absence of a trailing byte on line 0; a design that kept line 0 driven, or paired the bits the wrong way round, is caught there. Monitors measure the high width of every clock pulse against the divider field, and the chip-select idle time against the programmed minimum. Separate checks catch a control word that changes while locked, a window write that starts SPI traffic in read mode, and user-mode chip select that does not follow bit 2.

// File: rtl/spiFlashPkg.sv
package spiFlashPkg;

  localparam int BYTE_W = 8;

  // Control word layout; field positions are decoded by the sequencer.
  typedef struct packed {
    logic [1:0] rsvdTop;
    logic [1:0] ioMode;      // [29:28]
    logic [3:0] csIdle;      // [27:24] idle time = 16 - value
    logic [7:0] rdOpcode;    // [23:16]
    logic [1:0] rsvdMid;
    logic       addr4;       // [13]
    logic       rsvdB12;
    logic [3:0] clkDiv;      // [11:8] half period = 8 - value[2:0]
    logic [1:0] dummyBytes;  // [7:6]
    logic [2:0] rsvdLow;
    logic       csHigh;      // [2]
    logic [1:0] mode;        // [1:0]
  } ctrlWord_t;

  localparam int CTRL_W = $bits(ctrlWord_t);

  localparam logic [1:0] MODE_FAST = 2'd1;
  localparam logic [1:0] MODE_USER = 2'd3;
  localparam logic [1:0] IO_DUAL   = 2'd2;
  localparam logic [BYTE_W-1:0] OPC_PLAIN_READ = 8'h03;

  // Strobes from the sequencer to the byte engine.
  typedef struct packed {
    logic              start;
    logic              dual;
    logic [BYTE_W-1:0] txByte;
  } engCmd_t;

endpackage

// File: rtl/spiRegs.sv
module spiRegs
  import spiFlashPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata,
  output ctrlWord_t         ctrl,
  output logic              cfgEn
);

  logic [CTRL_W-1:0] ctrlQ;
  logic              cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      cfgQ  <= 1'b0;
    end else if (regWr) begin
      if (!regSel)     cfgQ  <= regWdata[0];
      else if (cfgQ)   ctrlQ <= regWdata;
    end
  end

  assign ctrl     = ctrlWord_t'(ctrlQ);
  assign cfgEn    = cfgQ;
  assign regRdata = regSel ? ctrlQ : {{(CTRL_W-1){1'b0}}, cfgQ};

endmodule

// File: rtl/spiByteEngine.sv
module spiByteEngine
  import spiFlashPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  engCmd_t           cmd,
  input  logic [3:0]        halfDiv,
  input  logic              io0In,
  input  logic              io1In,
  output logic              sclk,
  output logic              io0Out,
  output logic              io0Oe,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rxByte
);

  localparam logic [3:0] SINGLE_STEPS = 4'(BYTE_W);
  localparam logic [3:0] DUAL_STEPS   = 4'(BYTE_W / 2);

  logic              busyQ, sclkQ, dualQ, doneQ;
  logic [3:0]        tick, stepsLeft;
  logic [BYTE_W-1:0] txSh, rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0; sclkQ <= 1'b0; dualQ <= 1'b0; doneQ <= 1'b0;
      tick <= '0; stepsLeft <= '0; txSh <= '0; rxSh <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (cmd.start) begin
          busyQ     <= 1'b1;
          sclkQ     <= 1'b0;
          tick      <= halfDiv - 4'd1;
          txSh      <= cmd.txByte;
          dualQ     <= cmd.dual;
          stepsLeft <= cmd.dual ? DUAL_STEPS : SINGLE_STEPS;
        end
      end else if (tick != '0) begin
        tick <= tick - 4'd1;
      end else begin
        tick <= halfDiv - 4'd1;
        if (!sclkQ) begin
          sclkQ     <= 1'b1;
          stepsLeft <= stepsLeft - 4'd1;
          if (dualQ) rxSh <= {rxSh[BYTE_W-3:0], io1In, io0In};
          else       rxSh <= {rxSh[BYTE_W-2:0], io1In};
        end else begin
          sclkQ <= 1'b0;
          if (stepsLeft == '0) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            txSh <= {txSh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk   = sclkQ;
  assign io0Out = txSh[BYTE_W-1];
  assign io0Oe  = !(busyQ && dualQ);
  assign busy   = busyQ;
  assign done   = doneQ;
  assign rxByte = rxSh;

endmodule

// File: rtl/spiSeq.sv
module spiSeq
  import spiFlashPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlWord_t         ctrl,
  input  logic              winReq,
  input  logic              winWr,
  input  logic [ADDR_W-1:0] winAddr,
  input  logic [BYTE_W-1:0] winWdata,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic [BYTE_W-1:0] engRx,
  output engCmd_t           cmd,
  output logic              winReady,
  output logic [BYTE_W-1:0] winRdata,
  output logic              csN,
  output logic [GAP_W-1:0]  gapLeft
);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_USER} seqState_t;

  seqState_t         st, stNxt;
  logic [2:0]        cnt, cntNxt;
  logic              issued, issuedNxt, readyQ, readyNxt, csNq, csNxt, activeNxt;
  logic [BYTE_W-1:0] rdataQ, rdataNxt;
  logic [GAP_W-1:0]  gapCnt, gapLoad;
  logic              userMode, fastMode;
  logic [2:0]        nAddr, nDummy, byteIdx;
  logic [ADDR_W-1:0] addrSh;

  assign userMode = (ctrl.mode == MODE_USER);
  assign fastMode = (ctrl.mode == MODE_FAST);
  assign nAddr    = ctrl.addr4 ? 3'd4 : 3'd3;
  assign nDummy   = fastMode ? {1'b0, ctrl.dummyBytes} : 3'd0;
  assign byteIdx  = nAddr - 3'd1 - cnt;
  assign addrSh   = winAddr >> {byteIdx, 3'b000};
  assign gapLoad  = GAP_W'(16) - GAP_W'(ctrl.csIdle);

  always_comb begin
    cmd.start  = (st != S_IDLE) && !issued && !engBusy;
    cmd.dual   = (st == S_DATA) && fastMode && (ctrl.ioMode == IO_DUAL);
    case (st)
      S_CMD:   cmd.txByte = fastMode ? ctrl.rdOpcode : OPC_PLAIN_READ;
      S_ADDR:  cmd.txByte = addrSh[BYTE_W-1:0];
      S_USER:  cmd.txByte = winWr ? winWdata : '0;
      default: cmd.txByte = '0;
    endcase
  end

  always_comb begin
    stNxt     = st;
    cntNxt    = cnt;
    issuedNxt = issued || cmd.start;
    readyNxt  = 1'b0;
    rdataNxt  = rdataQ;
    case (st)
      S_IDLE: begin
        if (winReq && !readyQ) begin
          if (userMode) begin
            stNxt = S_USER;
          end else if (winWr) begin
            readyNxt = 1'b1;
          end else if (gapCnt == '0) begin
            stNxt  = S_CMD;
            cntNxt = '0;
          end
        end
      end
      S_CMD: if (engDone) begin
        stNxt  = S_ADDR;
        cntNxt = '0;
      end
      S_ADDR: if (engDone) begin
        if (cnt == nAddr - 3'd1) begin
          cntNxt = '0;
          stNxt  = (nDummy != '0) ? S_DUMMY : S_DATA;
        end else begin
          cntNxt = cnt + 3'd1;
        end
      end
      S_DUMMY: if (engDone) begin
        if (cnt == nDummy - 3'd1) stNxt = S_DATA;
        else                      cntNxt = cnt + 3'd1;
      end
      S_DATA, S_USER: if (engDone) begin
        stNxt    = S_IDLE;
        readyNxt = 1'b1;
        rdataNxt = engRx;
      end
      default: stNxt = S_IDLE;
    endcase
    if (engDone) issuedNxt = 1'b0;
    activeNxt = (stNxt == S_CMD) || (stNxt == S_ADDR) ||
                (stNxt == S_DUMMY) || (stNxt == S_DATA);
    csNxt     = ctrl.csHigh || (!userMode && !activeNxt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; cnt <= '0; issued <= 1'b0; readyQ <= 1'b0;
      rdataQ <= '0; csNq <= 1'b1; gapCnt <= '0;
    end else begin
      st     <= stNxt;
      cnt    <= cntNxt;
      issued <= issuedNxt;
      readyQ <= readyNxt;
      rdataQ <= rdataNxt;
      csNq   <= csNxt;
      if (csNxt && !csNq)    gapCnt <= gapLoad;
      else if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
    end
  end

  assign winReady = readyQ;
  assign winRdata = rdataQ;
  assign csN      = csNq;
  assign gapLeft  = gapCnt;

endmodule

// File: rtl/spiFlashCtl.sv
module spiFlashCtl
  import spiFlashPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              winReq,
  input  logic              winWr,
  input  logic [ADDR_W-1:0] winAddr,
  input  logic [7:0]        winWdata,
  output logic              winReady,
  output logic [7:0]        winRdata,
  output logic              spiClk,
  output logic              spiCsN,
  output logic              spiIo0Out,
  output logic              spiIo0Oe,
  input  logic              spiIo0In,
  input  logic              spiIo1In
);

  localparam int GAP_W = 5;

  ctrlWord_t         ctrl;
  logic [31:0]       ctrlBits;
  logic [1:0]        ctrlMode;
  logic              cfgEn, engBusy, engDone;
  logic [3:0]        halfDiv;
  logic [BYTE_W-1:0] engRx;
  logic [GAP_W-1:0]  gapLeft;
  engCmd_t           engCmd;

  assign ctrlBits = ctrl;
  assign ctrlMode = ctrl.mode;
  assign halfDiv  = 4'd8 - {1'b0, ctrl.clkDiv[2:0]};

  spiRegs u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .ctrl(ctrl), .cfgEn(cfgEn)
  );

  spiSeq #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .winReq(winReq), .winWr(winWr), .winAddr(winAddr), .winWdata(winWdata),
    .engBusy(engBusy), .engDone(engDone), .engRx(engRx), .cmd(engCmd),
    .winReady(winReady), .winRdata(winRdata), .csN(spiCsN), .gapLeft(gapLeft)
  );

  spiByteEngine u_eng (
    .clk(clk), .rstN(rstN), .cmd(engCmd), .halfDiv(halfDiv),
    .io0In(spiIo0In), .io1In(spiIo1In), .sclk(spiClk),
    .io0Out(spiIo0Out), .io0Oe(spiIo0Oe), .busy(engBusy),
    .done(engDone), .rxByte(engRx)
  );

endmodule

// File: rtl/spiFlashChk.sv
module spiFlashChk (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic        regSel,
  input logic        cfgEn,
  input logic [31:0] ctrlBits,
  input logic [1:0]  ctrlMode,
  input logic        engBusy,
  input logic        spiClk,
  input logic        spiCsN,
  input logic        spiIo0Oe,
  input logic        winReady,
  input logic [4:0]  gapLeft
);

  // R1: a locked control word does not change on a write
  p_ctrl_locked_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel && !cfgEn) |=> $stable(ctrlBits));

  // R9: serial clock rests low whenever no byte is moving
  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !engBusy |-> !spiClk);

  // R8: an automatic read lowers chip select only after the idle window ran out
  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(spiCsN) && ctrlMode != 2'd3) |-> (gapLeft == 5'd0));

  // R5: line 0 is released only inside a selected transaction
  p_dual_framed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!spiIo0Oe && !ctrlBits[2]) |-> !spiCsN);

  // R11: completion is a single-cycle pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    winReady |=> !winReady);

endmodule

bind spiFlashCtl spiFlashChk i_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .cfgEn(cfgEn),
  .ctrlBits(ctrlBits), .ctrlMode(ctrlMode), .engBusy(engBusy),
  .spiClk(spiClk), .spiCsN(spiCsN), .spiIo0Oe(spiIo0Oe),
  .winReady(winReady), .gapLeft(gapLeft)
);

// File: tb/test_spiFlashCtl.sv
module test_spiFlashCtl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regSel = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic        winReq = 1'b0, winWr = 1'b0;
  logic [31:0] winAddr = '0;
  logic [7:0]  winWdata = '0, winRdata;
  logic        winReady, spiClk, spiCsN, spiIo0Out, spiIo0Oe;
  logic        spiIo0In, spiIo1In;

  always #5ns clk = ~clk;

  spiFlashCtl i_spiFlashCtl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .winReq(winReq), .winWr(winWr),
    .winAddr(winAddr), .winWdata(winWdata), .winReady(winReady),
    .winRdata(winRdata), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiIo0Out(spiIo0Out), .spiIo0Oe(spiIo0Oe), .spiIo0In(spiIo0In),
    .spiIo1In(spiIo1In)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural flash: queue of bytes seen on line 0, response bits by rise count
  logic [7:0] capQ[$];
  logic [7:0] capSh = '0, respByte = '0;
  int capBits = 0, rises = 0, respStart = 1000, sclkRises = 0;
  bit respDual = 0;

  always @(posedge spiClk or posedge spiCsN) begin
    if (spiCsN) begin
      rises = 0; capBits = 0;
    end else begin
      if (spiIo0Oe) begin
        capSh = {capSh[6:0], spiIo0Out};
        capBits++;
        if (capBits == 8) begin capQ.push_back(capSh); capBits = 0; end
      end
      rises++;
    end
  end

  always @(posedge spiClk) sclkRises++;

  always @* begin
    int k;
    k = rises - respStart;
    spiIo1In = 1'b0; spiIo0In = 1'b0;
    if (!respDual && k >= 0 && k < 8) spiIo1In = respByte[7-k];
    if (respDual && k >= 0 && k < 4) begin
      spiIo1In = respByte[7-2*k];
      spiIo0In = respByte[6-2*k];
    end
  end

  // Timing monitors: clock high width (R9) and chip-select idle time (R8)
  int expHp = 8, expGap = 16, hiCnt = 0, csHiCnt = 0, csFalls = 0;
  bit sclkPrev = 0, csPrev = 1, armed = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (spiClk) hiCnt++;
      else if (sclkPrev) begin chk(hiCnt == expHp, "R9 clock high width", hiCnt, expHp); hiCnt = 0; end
      sclkPrev = spiClk;
      if (spiCsN) csHiCnt++;
      else if (csPrev) begin
        if (armed) chk(csHiCnt >= expGap, "R8 chip select idle", csHiCnt, expGap);
        armed = 1; csHiCnt = 0; csFalls++;
      end
      csPrev = spiCsN;
    end
  end

  bit cfgOn = 0;

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk); regWr = 1'b0;
    if (!sel) cfgOn = d[0];
    else if (cfgOn) begin
      expHp = 8 - int'(d[10:8]);
      expGap = 16 - int'(d[27:24]);
    end
  endtask

  task automatic regRead(input logic sel, output logic [31:0] d);
    @(negedge clk); regSel = sel;
    #1ns d = regRdata;
  endtask

  task automatic winAcc(input bit wr, input logic [31:0] a, input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk); winReq = 1'b1; winWr = wr; winAddr = a; winWdata = wd;
    do @(negedge clk); while (!winReady);
    rd = winRdata; winReq = 1'b0; winWr = 1'b0;
    @(negedge clk);
    chk(!winReady, "R11 ready is one cycle", winReady, 0);
  endtask

  task automatic flashRead(input string tag, input logic [7:0] opc, input int nAddr, input int nDummy,
                           input bit dual, input logic [31:0] a, input logic [7:0] resp);
    logic [7:0] expQ[$];
    logic [7:0] got;
    int base;
    base = capQ.size();
    respByte = resp; respDual = dual; respStart = (1 + nAddr + nDummy) * 8;
    expQ.push_back(opc);
    for (int i = nAddr - 1; i >= 0; i--) expQ.push_back(a[8*i +: 8]);
    for (int i = 0; i < nDummy; i++) expQ.push_back(8'h00);
    if (!dual) expQ.push_back(8'h00);
    winAcc(1'b0, a, 8'h00, got);
    chk(got == resp, {tag, " data byte"}, got, resp);
    chk(capQ.size() - base == expQ.size(), {tag, " byte count"}, capQ.size() - base, expQ.size());
    for (int i = 0; i < expQ.size(); i++)
      if (base + i < capQ.size()) chk(capQ[base+i] == expQ[i], {tag, " sent byte"}, capQ[base+i], expQ[i]);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      chk(0, "watchdog", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic [7:0]  b;
    int base, falls, rs;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(spiCsN == 1'b1, "R10 chip select", spiCsN, 1);
    chk(spiClk == 1'b0, "R10 clock", spiClk, 0);
    chk(winReady == 1'b0, "R10 ready", winReady, 0);
    regRead(1'b1, rv); chk(rv == 32'h0, "R10 control word", rv, 0);
    regRead(1'b0, rv); chk(rv == 32'h0, "R10 config word", rv, 0);

    // R1 lock
    regWrite(1'b1, 32'h0E3B_0740);
    regRead(1'b1, rv); chk(rv == 32'h0, "R1 locked write ignored", rv, 0);
    regWrite(1'b0, 32'hFFFF_FFFF);
    regRead(1'b0, rv); chk(rv == 32'h1, "R1 config bit 0 only", rv, 1);
    regWrite(1'b1, 32'h0E3B_0740);
    regRead(1'b1, rv); chk(rv == 32'h0E3B_0740, "R1 unlocked write", rv, 32'h0E3B_0740);

    // R2 normal read, opcode and dummy fields ignored; R4 three address bytes
    repeat (20) @(negedge clk);
    flashRead("R2 R4 normal read", 8'h03, 3, 0, 0, 32'h0012_3456, 8'hA5);
    regWrite(1'b1, 32'h0E3B_0742);
    repeat (20) @(negedge clk);
    flashRead("R2 mode 2 as normal", 8'h03, 3, 0, 0, 32'h0065_4321, 8'h5A);

    // R3 fast read, one and two dummy bytes, divide by 8
    regWrite(1'b1, 32'h0A0B_0441);
    repeat (20) @(negedge clk);
    flashRead("R3 fast read one dummy", 8'h0B, 3, 1, 0, 32'h00AB_CDEF, 8'h5C);
    regWrite(1'b1, 32'h0A0B_0481);
    repeat (20) @(negedge clk);
    flashRead("R3 fast read two dummy", 8'h0B, 3, 2, 0, 32'h0001_0203, 8'hE7);

    // R5 dual data read
    regWrite(1'b1, 32'h2E3B_0741);
    repeat (20) @(negedge clk);
    flashRead("R5 dual read", 8'h3B, 3, 1, 1, 32'h0070_8090, 8'h96);
    flashRead("R5 dual read pattern", 8'h3B, 3, 1, 1, 32'h0000_0001, 8'h1E);

    // R4 four address bytes
    regWrite(1'b1, 32'h0E3B_2740);
    repeat (20) @(negedge clk);
    flashRead("R4 four byte address", 8'h03, 4, 0, 0, 32'hDEAD_BE01, 8'h3C);

    // R8 back-to-back reads with the longest idle time, slowest clock
    regWrite(1'b1, 32'h0000_0040);
    repeat (20) @(negedge clk);
    flashRead("R8 R9 slow read a", 8'h03, 3, 0, 0, 32'h0000_1111, 8'h81);
    flashRead("R8 R9 slow read b", 8'h03, 3, 0, 0, 32'h0000_2222, 8'h18);

    // R7 window write outside user mode
    base = capQ.size(); falls = csFalls; rs = sclkRises;
    winAcc(1'b1, 32'h0000_0000, 8'hAB, b);
    chk(sclkRises == rs, "R7 no clock edges", sclkRises - rs, 0);
    chk(csFalls == falls, "R7 chip select stays high", csFalls - falls, 0);
    chk(capQ.size() == base, "R7 nothing shifted", capQ.size() - base, 0);

    // R6 user mode framing
    regWrite(1'b1, 32'h0000_0707);
    repeat (20) @(negedge clk);
    chk(spiCsN == 1'b1, "R6 bit 2 holds chip select high", spiCsN, 1);
    regWrite(1'b1, 32'h0000_0703);
    @(negedge clk);
    chk(spiCsN == 1'b0, "R6 bit 2 clear lowers chip select", spiCsN, 0);
    base = capQ.size();
    winAcc(1'b1, 32'h0, 8'h9F, b);
    winAcc(1'b1, 32'h0, 8'h12, b);
    respByte = 8'hC3; respDual = 0; respStart = rises;
    winAcc(1'b0, 32'h0, 8'h00, b);
    chk(b == 8'hC3, "R6 raw read byte", b, 8'hC3);
    chk(capQ.size() - base == 3, "R6 raw byte count", capQ.size() - base, 3);
    if (capQ.size() - base == 3) begin
      chk(capQ[base] == 8'h9F, "R6 first raw byte", capQ[base], 8'h9F);
      chk(capQ[base+1] == 8'h12, "R6 second raw byte", capQ[base+1], 8'h12);
      chk(capQ[base+2] == 8'h00, "R6 read shifts zero", capQ[base+2], 8'h00);
    end
    chk(spiCsN == 1'b0, "R6 chip select held between bytes", spiCsN, 0);
    regWrite(1'b1, 32'h0000_0707);
    @(negedge clk);
    chk(spiCsN == 1'b1, "R6 framing ends high", spiCsN, 1);

    // back to automatic read
    regWrite(1'b1, 32'h0E3B_0740);
    flashRead("R2 read after user mode", 8'h03, 3, 0, 0, 32'h0033_4455, 8'h6D);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule